// File: doc/BRIEF.md
# CAN Operating Mode Handshake Controller

This block sequences a CAN controller between three operating modes: normal, initialization and sleep. Software asks for a mode by holding a request bit. The block answers through two acknowledge flags, which hardware both sets and clears.

Entering initialization or sleep takes effect on the next clock. Leaving either one works differently. Once both request bits are low, the block stays in its current mode until the receive line has been idle on the bus. Idle means eleven consecutive recessive bits, counted only at bit-time strobes. When the eleventh bit arrives, the block returns to normal mode and drops the acknowledge flag.

The block also holds a sticky error-interrupt status flag. A qualified error event sets it, and a software write-one-to-clear pulse clears it. The flag drives the interrupt line when the global error-interrupt enable is set.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, sleep_ack_o is 1, init_ack_o is 0, err_flag_o is 0 and irq_o is 0.
- R2: A cycle with init_req_i high gives init_ack_o=1 and sleep_ack_o=0 after the next clock edge, whatever sleep_req_i is.
- R3: A cycle with sleep_req_i high and init_req_i low gives sleep_ack_o=1 and init_ack_o=0 after the next clock edge.
- R4: In sleep mode with both requests low, sleep_ack_o stays 1 until eleven consecutive strobed recessive bits (rx_bit_i=1 with bit_stb_i=1) have been seen. It drops to 0 on the edge that samples the eleventh bit. Cycles without a strobe neither count nor break the run.
- R5: In initialization mode with both requests low, init_ack_o clears under the same eleven-recessive-bit rule.
- R6: A strobed dominant bit (rx_bit_i=0) during the wait restarts the count from zero. A request rising during the wait also discards the count.
- R7: init_ack_o and sleep_ack_o are never 1 at the same time.
- R8: err_flag_o sets on the edge after a cycle with err_evt_i=1 and err_src_en_i=1. An event with err_src_en_i=0 leaves it unchanged.
- R9: err_flag_o stays set until a cycle with err_clr_i=1 clears it. If a qualified event and a clear arrive in the same cycle, the flag ends up set.
- R10: irq_o is 1 exactly when err_flag_o is 1 and err_ie_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_req_i | input | 1 | Initialization mode request |
| sleep_req_i | input | 1 | Sleep mode request |
| rx_bit_i | input | 1 | Sampled receive bit, 1 = recessive |
| bit_stb_i | input | 1 | Bit-time strobe qualifying rx_bit_i |
| err_evt_i | input | 1 | Error-status condition pulse |
| err_src_en_i | input | 1 | Per-source enable for the error event |
| err_ie_i | input | 1 | Global error-interrupt enable |
| err_clr_i | input | 1 | Write-one-to-clear pulse for the error flag |
| init_ack_o | output | 1 | Initialization acknowledge |
| sleep_ack_o | output | 1 | Sleep acknowledge |
| err_flag_o | output | 1 | Sticky error-interrupt status |
| irq_o | output | 1 | Status-change interrupt |

## Verification
The acknowledge flags come straight from the mode register, so a wrong mode shows at the ports one edge after the request that caused it. An idle counter that is off by one, or that fails to restart, shows up as the acknowledge dropping one strobe early or late. Directed runs of ten recessive bits, interrupted by a dominant bit and by cycles without a strobe, expose that error at the exact edge. A flaw in the sticky error flag shows on err_flag_o and irq_o one edge after a set, a clear, or a set and clear in the same cycle.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_INIT   = 2'd1,
    MODE_SLEEP  = 2'd2
  } mode_e;
endpackage

// File: rtl/can_idle_detect.sv
module can_idle_detect #(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic rx_bit_i,
  input  logic bit_stb_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && bit_stb_i && rx_bit_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || done_o)        cnt_q <= '0;
    else if (bit_stb_i) begin
      if (rx_bit_i) cnt_q <= cnt_q + 1'b1;
      else          cnt_q <= '0;   // dominant bit restarts the run
    end
  end
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  init_req_i,
  input  logic  sleep_req_i,
  input  logic  idle_done_i,
  output logic  wait_o,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;

  // exit wait: held mode with both requests released
  assign wait_o = (mode_q != MODE_NORMAL) && !init_req_i && !sleep_req_i;

  always_comb begin
    mode_d = mode_q;
    if (init_req_i)       mode_d = MODE_INIT;
    else if (sleep_req_i) mode_d = MODE_SLEEP;
    else if (idle_done_i) mode_d = MODE_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_SLEEP;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/can_err_irq.sv
module can_err_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic src_en_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (evt_i && src_en_i)  flag_q <= 1'b1;  // set beats clear
    else if (clr_i)              flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_i;
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_req_i,
  input  logic sleep_req_i,
  input  logic rx_bit_i,
  input  logic bit_stb_i,
  input  logic err_evt_i,
  input  logic err_src_en_i,
  input  logic err_ie_i,
  input  logic err_clr_i,
  output logic init_ack_o,
  output logic sleep_ack_o,
  output logic err_flag_o,
  output logic irq_o
);
  logic  wait_w, done_w;
  mode_e mode_w;

  can_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_req_i  (init_req_i),
    .sleep_req_i (sleep_req_i),
    .idle_done_i (done_w),
    .wait_o      (wait_w),
    .mode_o      (mode_w)
  );

  can_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (wait_w),
    .rx_bit_i  (rx_bit_i),
    .bit_stb_i (bit_stb_i),
    .done_o    (done_w)
  );

  can_err_irq u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (err_evt_i),
    .src_en_i (err_src_en_i),
    .clr_i    (err_clr_i),
    .ie_i     (err_ie_i),
    .flag_o   (err_flag_o),
    .irq_o    (irq_o)
  );

  assign init_ack_o  = (mode_w == MODE_INIT);
  assign sleep_ack_o = (mode_w == MODE_SLEEP);
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic init_req_i,
  input logic sleep_req_i,
  input logic rx_bit_i,
  input logic bit_stb_i,
  input logic err_evt_i,
  input logic err_src_en_i,
  input logic err_ie_i,
  input logic err_clr_i,
  input logic init_ack_o,
  input logic sleep_ack_o,
  input logic err_flag_o,
  input logic irq_o
);
  p_init_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_i |=> (init_ack_o && !sleep_ack_o));

  p_sleep_enter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req_i && !init_req_i) |=> (sleep_ack_o && !init_ack_o));

  p_sleep_exit_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sleep_ack_o) && !init_ack_o) |->
      $past(bit_stb_i && rx_bit_i && !sleep_req_i && !init_req_i));

  p_init_exit_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(init_ack_o) && !sleep_ack_o) |->
      $past(bit_stb_i && rx_bit_i && !sleep_req_i && !init_req_i));

  p_ack_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(init_ack_o && sleep_ack_o));

  p_err_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_evt_i && err_src_en_i) |=> err_flag_o);

  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flag_o && !err_clr_i) |=> err_flag_o);

  p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (err_ie_i && err_flag_o));
endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (.*);

// File: tb/can_mode_ctrl_test.sv
module can_mode_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic init_req = 0, sleep_req = 0, rx = 1, stb = 0;
  logic evt = 0, src_en = 0, ie = 0, clr = 0;
  logic init_ack, sleep_ack, err_flag, irq;

  int total = 0, bad = 0;
  int m_mode = 2;   // 0 normal, 1 init, 2 sleep
  int m_cnt  = 0;
  bit m_flag = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  can_mode_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .init_req_i(init_req), .sleep_req_i(sleep_req),
    .rx_bit_i(rx), .bit_stb_i(stb), .err_evt_i(evt), .err_src_en_i(src_en),
    .err_ie_i(ie), .err_clr_i(clr), .init_ack_o(init_ack), .sleep_ack_o(sleep_ack),
    .err_flag_o(err_flag), .irq_o(irq)
  );

  task automatic chk(input bit act, input bit exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b @%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_flag(bit f, bit e, bit en, bit c);
    return (e && en) || (f && !c);
  endfunction

  task automatic model_step();
    if (init_req)       begin m_mode = 1; m_cnt = 0; end
    else if (sleep_req) begin m_mode = 2; m_cnt = 0; end
    else if (m_mode != 0) begin
      if (stb) begin
        if (!rx) m_cnt = 0;
        else if (m_cnt == 10) begin m_mode = 0; m_cnt = 0; end
        else m_cnt++;
      end
    end else m_cnt = 0;
    m_flag = exp_flag(m_flag, evt, src_en, clr);
  endtask

  task automatic compare();
    chk(init_ack,  m_mode == 1, "init_ack");
    chk(sleep_ack, m_mode == 2, "sleep_ack");
    chk(init_ack && sleep_ack, 1'b0, "R7 exclusive acks");
    chk(err_flag,  m_flag, "err_flag");
    chk(irq,       m_flag && ie, "irq");
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    evt = 0; clr = 0; stb = 0;
  endtask

  task automatic bits(input int n, input bit v);
    for (int i = 0; i < n; i++) begin
      rx = v; stb = 1; cyc();
      rx = 0; cyc();   // gap without strobe, dominant level ignored
    end
    rx = 1;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1;
    @(negedge clk); compare();

    tag = "R4"; sleep_req = 0;
    bits(10, 1);
    chk(sleep_ack, 1'b1, "R4 held after 10 bits");
    tag = "R6"; bits(1, 0); bits(10, 1);
    chk(sleep_ack, 1'b1, "R6 restart after dominant");
    tag = "R4"; bits(1, 1);
    chk(sleep_ack, 1'b0, "R4 release after 11th bit");

    tag = "R2"; init_req = 1; sleep_req = 1; cyc();
    chk(init_ack, 1'b1, "R2 init beats sleep");
    init_req = 0; sleep_req = 0;
    tag = "R5"; bits(5, 1);
    tag = "R6"; sleep_req = 1; cyc(); sleep_req = 0; init_req = 1; cyc(); init_req = 0;
    tag = "R5"; bits(10, 1);
    chk(init_ack, 1'b1, "R5 held after 10 bits");
    bits(1, 1);
    chk(init_ack, 1'b0, "R5 release after 11th bit");
    tag = "R3"; sleep_req = 1; cyc();
    chk(sleep_ack, 1'b1, "R3 sleep entry");
    sleep_req = 0;

    tag = "R8"; evt = 1; src_en = 0; cyc();
    chk(err_flag, 1'b0, "R8 unqualified event");
    evt = 1; src_en = 1; cyc();
    chk(err_flag, 1'b1, "R8 qualified event");
    tag = "R10"; ie = 0; cyc(); chk(irq, 1'b0, "R10 masked");
    ie = 1; cyc(); chk(irq, 1'b1, "R10 enabled");
    tag = "R9"; evt = 1; clr = 1; cyc();
    chk(err_flag, 1'b1, "R9 set wins");
    cyc(); chk(err_flag, 1'b1, "R9 sticky");
    clr = 1; cyc(); chk(err_flag, 1'b0, "R9 cleared");

    tag = "R2 R3 R4 R5 R6 R8 R9 R10 random";
    for (int i = 0; i < 4000; i++) begin
      if (i % 40 == 0) begin
        int r = $urandom_range(0, 9);
        init_req  = (r == 0) || (r == 1);
        sleep_req = (r == 1) || (r == 2);
      end
      rx     = ($urandom_range(0, 15) != 0);
      stb    = ($urandom_range(0, 2) == 0);
      evt    = ($urandom_range(0, 15) == 0);
      src_en = $urandom_range(0, 1);
      clr    = ($urandom_range(0, 11) == 0);
      ie     = ($urandom_range(0, 7) != 0);
      cyc();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule